// File: doc/BRIEF.md
# Modulated Edge PWM Generator

This block is a counter-based digital pulse width modulator. A free-running position counter wraps at a programmed period. Each switching period produces two timing events, `t1` and `t2`, from a duty command. Their positions follow one of three modulation styles:

- Trailing edge: the first event is pinned and the second moves.
- Leading edge: the second event is pinned and the first moves.
- Dual edge: both events move symmetrically about the centre.

In bridge operation the period splits into two half-cycles. Each half-cycle is tagged even or odd, and the events are placed within each half.

Every PWM output has two encoded selectors: one picks the event that sets it and one picks the event that clears it. The choices are:

- the plain events;
- events qualified to the even or the odd half-cycle;
- copies of the events delayed by a programmable number of clocks;
- the falling edge of one of two rectification-sense inputs (set only).

The period, duty, mode, delay and selector settings are captured only at the period boundary. This means a change made mid-cycle cannot produce a glitch.

Top module: `pwmEdgeGen`

## Requirements
- R1: While `rstN` is low every PWM output is low, and after release no event fires before the first configuration capture.
- R2: Trailing-edge mode (`modeIn`=0, also used for 3): within each half of length H (H = period in single mode, period/2 in bridge mode), `t1` fires at position 0 and `t2` at position D, where D = min(duty, H).
- R3: Leading-edge mode (`modeIn`=1): `t1` fires at position H−D. `t2` marks the end of the half and is issued at position 0 of the following half. In bridge mode it carries the parity of the half that just ended. It is suppressed when D = H.
- R4: Dual-edge mode (`modeIn`=2): `t1` fires at floor(H/2) − floor(D/2) and `t2` at that position plus D, so both edges sit about the midpoint of each half.
- R5: Half-cycle parity starts even after each capture and toggles at every half end in bridge mode. It stays even in single mode. Selector codes 2/3 respond to `t1`/`t2` in even halves only, and codes 4/5 respond to `t1`/`t2` in odd halves only.
- R6: Codes 6 and 7 select `t1` and `t2` delayed by `delayIn` clocks. A delay of 0 gives the undelayed event.
- R7: Rise-selector code 8 sets the output three clock edges after a falling transition on `senseA`. Codes 9 to 15 do the same for `senseB`. An output ignores the sense input it has not selected.
- R8: Each output's 3-bit fall selector uses the same encoding for codes 0 to 7: 0 `t1`, 1 `t2`, 2 `t1` even, 3 `t2` even, 4 `t1` odd, 5 `t2` odd, 6 `t1` delayed, 7 `t2` delayed. An output holds its value in cycles with neither of its events.
- R9: When an output's set event and clear event fall in the same clock cycle, the output goes low.
- R10: The duty command is clamped to H, so D = 0 gives a constant low output and D = H gives a constant high output.
- R11: Period, duty, mode, bridge, delay and selector inputs are captured only at the end of a full period (the odd half in bridge mode). A change made mid-period takes effect in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodIn | input | CNT_W | Switching period in clocks (at least 2, at least 4 in bridge mode) |
| dutyIn | input | CNT_W | Duty command in clocks per half |
| modeIn | input | 2 | 0 trailing, 1 leading, 2 dual edge |
| bridgeIn | input | 1 | 1 selects bridge (two half-cycles) operation |
| delayIn | input | DLY_W | Delay in clocks for the delayed events |
| riseSelIn | input | NUM_OUT*4 | Set-event selector, 4 bits per output |
| fallSelIn | input | NUM_OUT*3 | Clear-event selector, 3 bits per output |
| senseA | input | 1 | Rectification sense input, asynchronous |
| senseB | input | 1 | Bridge-variant rectification sense input, asynchronous |
| pwmOut | output | NUM_OUT | PWM outputs |

## Verification
An event at counter position p changes an output at the clock edge that ends that position's cycle, so the output is sampled on the following falling edge. A sense falling edge passes through two synchroniser flops and an edge register, so its effect is checked at the third rising edge and not at the second. The bench keeps its own position, parity and captured-configuration model, stepping one cycle per loop iteration. It snapshots the inputs at each rising edge so that captures happen in the same cycle as in the design. Every sample point is compared against this model.

// File: rtl/pwmEdgePkg.sv
package pwmEdgePkg;

  typedef enum logic [1:0] {
    MOD_TRAIL = 2'd0,
    MOD_LEAD  = 2'd1,
    MOD_DUAL  = 2'd2
  } modMode_e;

  // Strobes from the control to the datapath, one clock cycle wide
  typedef struct packed {
    logic load;    // configuration capture this cycle
    logic t1;
    logic t2;
    logic t1Odd;   // parity tag of t1
    logic t2Odd;   // parity tag of t2
    logic t1d;     // delayed t1
    logic t2d;     // delayed t2
  } evStrobe_t;

endpackage

// File: rtl/pwmEdgeCtrl.sv
module pwmEdgeCtrl
  import pwmEdgePkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodIn,
  input  logic [CNT_W-1:0] dutyIn,
  input  logic [1:0]       modeIn,
  input  logic             bridgeIn,
  input  logic [DLY_W-1:0] delayIn,
  output evStrobe_t        ev
);

  localparam int NUM_EV = 2;

  logic             started;
  logic [CNT_W-1:0] pos;
  logic             halfOdd;
  logic [CNT_W-1:0] periodQ;
  logic [CNT_W-1:0] dutyQ;
  logic [1:0]       modeQ;
  logic             bridgeQ;
  logic [DLY_W-1:0] dlyQ;

  logic [CNT_W-1:0] halfLen, dc, center, t1Pos, t2Pos;
  logic             atEnd, load;
  logic [NUM_EV-1:0] hit, hitOdd, dHit;

  always_comb begin
    halfLen = bridgeQ ? (periodQ >> 1) : periodQ;
    dc      = (dutyQ > halfLen) ? halfLen : dutyQ;
    center  = halfLen >> 1;
    case (modeQ)
      MOD_LEAD: begin t1Pos = halfLen - dc;        t2Pos = '0;         end
      MOD_DUAL: begin t1Pos = center - (dc >> 1);  t2Pos = t1Pos + dc; end
      default:  begin t1Pos = '0;                  t2Pos = dc;         end
    endcase
    hit[0]    = started && (pos == t1Pos);
    hit[1]    = started && (pos == t2Pos) && !(modeQ == MOD_LEAD && dc == halfLen);
    hitOdd[0] = halfOdd;
    // leading-edge t2 closes the half that just ended
    hitOdd[1] = (modeQ == MOD_LEAD && bridgeQ) ? ~halfOdd : halfOdd;
    atEnd     = (halfLen <= CNT_W'(1)) || (pos >= halfLen - CNT_W'(1));
    load      = !started || (atEnd && (!bridgeQ || halfOdd));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      pos     <= '0;
      halfOdd <= 1'b0;
      periodQ <= '0;
      dutyQ   <= '0;
      modeQ   <= '0;
      bridgeQ <= 1'b0;
      dlyQ    <= '0;
    end else begin
      started <= 1'b1;
      if (load) begin
        periodQ <= periodIn;
        dutyQ   <= dutyIn;
        modeQ   <= modeIn;
        bridgeQ <= bridgeIn;
        dlyQ    <= delayIn;
        pos     <= '0;
        halfOdd <= 1'b0;
      end else if (atEnd) begin
        pos     <= '0;
        halfOdd <= ~halfOdd;
      end else begin
        pos     <= pos + CNT_W'(1);
      end
    end
  end

  // one countdown per event for the delayed copies
  for (genvar k = 0; k < NUM_EV; k++) begin : gDelay
    logic [DLY_W-1:0] dCnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          dCnt <= '0;
      else if (hit[k] && dlyQ != '0)      dCnt <= dlyQ;
      else if (dCnt != '0)                dCnt <= dCnt - DLY_W'(1);
    end
    assign dHit[k] = (hit[k] && dlyQ == '0) || (dCnt == DLY_W'(1));
  end

  always_comb begin
    ev.load  = load;
    ev.t1    = hit[0];
    ev.t2    = hit[1];
    ev.t1Odd = hitOdd[0];
    ev.t2Odd = hitOdd[1];
    ev.t1d   = dHit[0];
    ev.t2d   = dHit[1];
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (pos == '0) && !halfOdd); // R11
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (started && !load) |=> ($stable(dutyQ) && $stable(modeQ) && $stable(periodQ))); // R11
  AST_BRIDGE_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (started && bridgeQ && atEnd && !halfOdd) |=> halfOdd); // R5
  AST_NO_EARLY_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> !(ev.t1 || ev.t2)); // R1

endmodule

// File: rtl/pwmEdgeDatapath.sv
module pwmEdgeDatapath
  import pwmEdgePkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  evStrobe_t            ev,
  input  logic [NUM_OUT*4-1:0] riseSelIn,
  input  logic [NUM_OUT*3-1:0] fallSelIn,
  input  logic                 senseA,
  input  logic                 senseB,
  output logic [NUM_OUT-1:0]   pwmOut
);

  localparam int RS_W = 4;
  localparam int FS_W = 3;

  logic [2:0] syncA, syncB;   // [0] first flop, [1] second flop, [2] previous
  logic       fallA, fallB;
  logic [NUM_OUT*RS_W-1:0] riseQ;
  logic [NUM_OUT*FS_W-1:0] fallQ;
  logic [NUM_OUT-1:0]      riseEv, fallEv, outQ;

  function automatic logic edgeHit(input logic [2:0] code, input evStrobe_t e);
    case (code)
      3'd0:    edgeHit = e.t1;
      3'd1:    edgeHit = e.t2;
      3'd2:    edgeHit = e.t1 && !e.t1Odd;
      3'd3:    edgeHit = e.t2 && !e.t2Odd;
      3'd4:    edgeHit = e.t1 && e.t1Odd;
      3'd5:    edgeHit = e.t2 && e.t2Odd;
      3'd6:    edgeHit = e.t1d;
      default: edgeHit = e.t2d;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 3'b111;
      syncB <= 3'b111;
    end else begin
      syncA <= {syncA[1:0], senseA};
      syncB <= {syncB[1:0], senseB};
    end
  end
  assign fallA = syncA[2] && !syncA[1];
  assign fallB = syncB[2] && !syncB[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ <= '0;
      fallQ <= '0;
    end else if (ev.load) begin
      riseQ <= riseSelIn;
      fallQ <= fallSelIn;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : gOut
    logic [RS_W-1:0] rCode;
    logic [FS_W-1:0] fCode;
    assign rCode = riseQ[i*RS_W +: RS_W];
    assign fCode = fallQ[i*FS_W +: FS_W];
    assign riseEv[i] = rCode[3] ? ((rCode == 4'd8) ? fallA : fallB)
                                : edgeHit(rCode[2:0], ev);
    assign fallEv[i] = edgeHit(fCode, ev);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          outQ[i] <= 1'b0;
      else if (fallEv[i]) outQ[i] <= 1'b0;
      else if (riseEv[i]) outQ[i] <= 1'b1;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
      fallEv[i] |=> !pwmOut[i]); // R9
    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
      (riseEv[i] && !fallEv[i]) |=> pwmOut[i]); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      (!riseEv[i] && !fallEv[i]) |=> $stable(pwmOut[i])); // R8
  end

  assign pwmOut = outQ;

  AST_RESET_LOW: assert property (@(posedge clk)
    !rstN |-> (pwmOut == '0)); // R1

endmodule

// File: rtl/pwmEdgeGen.sv
module pwmEdgeGen
  import pwmEdgePkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DLY_W   = 4,
  parameter int NUM_OUT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     periodIn,
  input  logic [CNT_W-1:0]     dutyIn,
  input  logic [1:0]           modeIn,
  input  logic                 bridgeIn,
  input  logic [DLY_W-1:0]     delayIn,
  input  logic [NUM_OUT*4-1:0] riseSelIn,
  input  logic [NUM_OUT*3-1:0] fallSelIn,
  input  logic                 senseA,
  input  logic                 senseB,
  output logic [NUM_OUT-1:0]   pwmOut
);

  evStrobe_t ev;

  pwmEdgeCtrl #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .periodIn(periodIn), .dutyIn(dutyIn),
    .modeIn(modeIn), .bridgeIn(bridgeIn), .delayIn(delayIn), .ev(ev)
  );

  pwmEdgeDatapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .ev(ev), .riseSelIn(riseSelIn),
    .fallSelIn(fallSelIn), .senseA(senseA), .senseB(senseB), .pwmOut(pwmOut)
  );

endmodule

// File: tb/pwmEdgeGen_tb.sv
module pwmEdgeGen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] cPeriod = 8'd10, cDuty = 8'd0;
  logic [1:0] cMode = 2'd0;
  logic       cBridge = 1'b0;
  logic [3:0] cDly = 4'd0;
  logic [3:0] cRise0 = 4'd0, cRise1 = 4'd0;
  logic [2:0] cFall0 = 3'd0, cFall1 = 3'd0;
  logic       senseA = 1'b1, senseB = 1'b1;
  logic [1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwmEdgeGen u_dut (
    .clk(clk), .rstN(rstN), .periodIn(cPeriod), .dutyIn(cDuty),
    .modeIn(cMode), .bridgeIn(cBridge), .delayIn(cDly),
    .riseSelIn({cRise1, cRise0}), .fallSelIn({cFall1, cFall0}),
    .senseA(senseA), .senseB(senseB), .pwmOut(pwmOut)
  );

  task automatic check(input string tag, input int idx, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s out%0d actual=%0b expected=%0b at %0t", tag, idx, act, exp, $time);
    end
  endtask

  function automatic bit selHit(input int code, input bit e1, input bit e2,
                                input bit o1, input bit o2, input bit d1, input bit d2);
    case (code)
      0: return e1;
      1: return e2;
      2: return e1 && !o1;
      3: return e2 && !o2;
      4: return e1 && o1;
      5: return e2 && o2;
      6: return d1;
      default: return d2;
    endcase
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Reference model run: starts from reset, compares every cycle
  task automatic runModel(input string tag, input int cycles, input int chgAt, input int newDuty);
    int mP, mD, mM, mB, mDl, mR0, mR1, mF0, mF1;
    int sP, sD, sM, sB, sDl, sR0, sR1, sF0, sF1;
    int pos, h, dc, t1p, t2p, last1, last2;
    bit odd, e1, e2, o1, o2, d1, d2, ex0, ex1;
    doReset();
    @(posedge clk);
    mP = cPeriod; mD = cDuty; mM = cMode; mB = cBridge; mDl = cDly;
    mR0 = cRise0; mR1 = cRise1; mF0 = cFall0; mF1 = cFall1;
    pos = 0; odd = 0; last1 = -1000; last2 = -1000; ex0 = 0; ex1 = 0;
    @(negedge clk);
    for (int c = 0; c < cycles; c++) begin
      h  = mB ? mP / 2 : mP;
      dc = (mD > h) ? h : mD;
      if (mM == 1) begin t1p = h - dc; t2p = 0; end
      else if (mM == 2) begin t1p = h / 2 - dc / 2; t2p = t1p + dc; end
      else begin t1p = 0; t2p = dc; end
      e1 = (pos == t1p);
      e2 = (pos == t2p) && !(mM == 1 && dc == h);
      o1 = odd;
      o2 = (mM == 1 && mB != 0) ? !odd : odd;
      d1 = (mDl == 0) ? e1 : (c == last1 + mDl);
      d2 = (mDl == 0) ? e2 : (c == last2 + mDl);
      if (e1) last1 = c;
      if (e2) last2 = c;
      if (selHit(mF0, e1, e2, o1, o2, d1, d2)) ex0 = 0;
      else if (selHit(mR0, e1, e2, o1, o2, d1, d2)) ex0 = 1;
      if (selHit(mF1, e1, e2, o1, o2, d1, d2)) ex1 = 0;
      else if (selHit(mR1, e1, e2, o1, o2, d1, d2)) ex1 = 1;
      @(posedge clk);
      sP = cPeriod; sD = cDuty; sM = cMode; sB = cBridge; sDl = cDly;
      sR0 = cRise0; sR1 = cRise1; sF0 = cFall0; sF1 = cFall1;
      @(negedge clk);
      check(tag, 0, pwmOut[0], ex0);
      check(tag, 1, pwmOut[1], ex1);
      if (h <= 1 || pos >= h - 1) begin
        if (mB == 0 || odd) begin
          mP = sP; mD = sD; mM = sM; mB = sB; mDl = sDl;
          mR0 = sR0; mR1 = sR1; mF0 = sF0; mF1 = sF1;
          pos = 0; odd = 0;
        end else begin
          pos = 0; odd = !odd;
        end
      end else pos++;
      if (c + 1 == chgAt) cDuty = 8'(newDuty);
    end
  endtask

  task automatic cfg(input int p, input int d, input int m, input int b, input int dl,
                     input int r0, input int f0, input int r1, input int f1);
    cPeriod = 8'(p); cDuty = 8'(d); cMode = 2'(m); cBridge = b[0]; cDly = 4'(dl);
    cRise0 = 4'(r0); cFall0 = 3'(f0); cRise1 = 4'(r1); cFall1 = 3'(f1);
  endtask

  task automatic testReset();
    cfg(10, 255, 0, 0, 0, 0, 1, 0, 1);
    rstN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1", 0, pwmOut[0], 1'b0);
      check("R1", 1, pwmOut[1], 1'b0);
    end
  endtask

  task automatic testTrail();
    cfg(10, 3, 0, 0, 0, 0, 1, 1, 0);  runModel("R2", 40, -1, 0);
    cfg(9, 6, 3, 0, 0, 0, 1, 1, 0);   runModel("R2", 30, -1, 0);
  endtask

  task automatic testLead();
    cfg(10, 3, 1, 0, 0, 0, 1, 1, 0);  runModel("R3", 40, -1, 0);
    cfg(16, 3, 1, 1, 0, 0, 1, 2, 3);  runModel("R3", 50, -1, 0);
  endtask

  task automatic testDual();
    cfg(12, 5, 2, 0, 0, 0, 1, 1, 0);  runModel("R4", 40, -1, 0);
    cfg(16, 4, 2, 1, 0, 0, 1, 4, 5);  runModel("R4", 50, -1, 0);
  endtask

  task automatic testParity();
    cfg(20, 4, 0, 1, 0, 2, 3, 4, 5);  runModel("R5", 60, -1, 0);
  endtask

  task automatic testDelay();
    cfg(12, 4, 0, 0, 3, 6, 7, 6, 1);  runModel("R6", 40, -1, 0);
    cfg(12, 4, 0, 0, 0, 6, 7, 0, 7);  runModel("R6", 30, -1, 0);
  endtask

  task automatic testFallSel();
    cfg(10, 5, 0, 0, 2, 1, 6, 0, 7);  runModel("R8", 40, -1, 0);
    cfg(16, 5, 0, 1, 0, 0, 3, 0, 5);  runModel("R8", 40, -1, 0);
  endtask

  task automatic testClearWins();
    cfg(10, 0, 0, 0, 0, 0, 1, 0, 0);  runModel("R9", 30, -1, 0);
  endtask

  task automatic testExtremes();
    cfg(10, 255, 0, 0, 0, 0, 1, 1, 0); runModel("R10", 30, -1, 0);
    cfg(10, 200, 1, 0, 0, 0, 1, 1, 0); runModel("R10", 30, -1, 0);
    cfg(10, 0, 2, 0, 0, 0, 1, 1, 0);   runModel("R10", 30, -1, 0);
    check("R10", 0, pwmOut[0], 1'b0);
  endtask

  task automatic testCapture();
    cfg(10, 4, 0, 0, 0, 0, 1, 1, 0);  runModel("R11", 40, 13, 8);
  endtask

  task automatic testSense();
    cfg(10, 255, 0, 0, 0, 8, 1, 9, 1);
    senseA = 1'b1; senseB = 1'b1;
    doReset();
    repeat (5) @(negedge clk);
    check("R7", 0, pwmOut[0], 1'b0);
    check("R7", 1, pwmOut[1], 1'b0);
    senseA = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7", 0, pwmOut[0], 1'b0);
    @(posedge clk); @(negedge clk);
    check("R7", 0, pwmOut[0], 1'b1);
    repeat (4) @(negedge clk);
    check("R7", 1, pwmOut[1], 1'b0);   // code 9 ignores senseA
    senseA = 1'b1;
    repeat (4) @(negedge clk);
    senseB = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7", 1, pwmOut[1], 1'b0);
    @(posedge clk); @(negedge clk);
    check("R7", 1, pwmOut[1], 1'b1);
    check("R7", 0, pwmOut[0], 1'b1);
    senseB = 1'b1;
  endtask

  initial begin
    testReset();
    testTrail();
    testLead();
    testDual();
    testParity();
    testDelay();
    testFallSel();
    testClearWins();
    testExtremes();
    testCapture();
    testSense();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule